// File: doc/BRIEF.md
# Display Memory Read-Modify-Write Write Unit

This unit applies a 16-bit write to one word of display memory at an internal execute address. A 2-bit logic operation selects how the data combines with the word already stored: plain replacement, XOR, clearing the bits where the data is 1, or setting the bits where the data is 1. A 2-bit lane select picks the whole word, only the low byte or only the high byte. The replace operation needs no memory read. The other three read the target word, wait for it to return, merge it and write it back. After each write the execute address moves by a signed horizontal step plus a signed vertical step times the line pitch, and wraps within 18 bits.

One request can repeat the same write a number of times, moving the address after each one. This allows the same unit to serve both a host data-write command and a DMA write stream. While an operation runs, `busy` is high and new requests are not taken. The execute address can be loaded while the unit is idle, and it can always be observed on `ead`.

The state machine has four states. **IDLE** waits for a request. **READ** issues a one-cycle memory read. **WAIT** holds until read data is valid. **WRITE** drives a one-cycle memory write and steps the address. The transitions are:
- IDLE goes to WRITE when a replace request is accepted.
- IDLE goes to READ when a merging request is accepted.
- READ always goes to WAIT.
- WAIT goes to WRITE when `mem_rvalid` is high.
- WRITE goes back to IDLE after the last repetition.
- Otherwise WRITE goes to READ for a merging operation, or stays in WRITE for a replace operation.

Top module: `dw_rmw_unit`

## Requirements
- R1: Operation code 0 (replace) writes the request data into the selected lanes, unchanged.
- R2: Operation code 1 writes the stored word XOR the data into the selected lanes.
- R3: Operation code 2 writes the stored word AND the inverted data into the selected lanes.
- R4: Operation code 3 writes the stored word OR the data into the selected lanes.
- R5: Lane select 0 writes both bytes, with `mem_be` = 2'b11. Lane select 2 writes only bits 7:0, taken from data bits 7:0, with `mem_be` = 2'b01. Lane select 3 writes only bits 15:8, taken from data bits 15:8, with `mem_be` = 2'b10. Bit 0 of `mem_be` enables bits 7:0 of the word.
- R6: A request with lane select 1 is refused. It causes no memory access, leaves `ead` unchanged and leaves `busy` low.
- R7: After each write, `ead` becomes (ead + step_x + step_y × pitch) mod 2^18. Both steps are two's-complement values in the range −2..1.
- R8: A request with repeat count N performs N+1 writes to successive stepped addresses.
- R9: A replace operation issues no memory read. A merging operation issues exactly one read per write and does not write until `mem_rvalid` has returned.
- R10: `busy` rises on the cycle after a request is accepted and falls after the last write. Each replace write takes 1 cycle. Each merging write takes 3 cycles plus one cycle for each cycle of read latency beyond the first.
- R11: `addr_load` loads `addr_value` into `ead` only while `busy` is low. While busy, it is ignored.
- R12: After reset, `busy`, `mem_rd` and `mem_wr` are low and `ead` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start request, taken when idle |
| req_mode | input | 2 | Logic operation code |
| req_type | input | 2 | Lane select |
| req_data | input | 16 | Write data |
| req_count | input | 8 | Repeat count (writes = count + 1) |
| step_x | input | 2 | Signed horizontal step |
| step_y | input | 2 | Signed vertical step, in lines |
| pitch | input | 8 | Words per display line |
| addr_load | input | 1 | Load execute address (idle only) |
| addr_value | input | 18 | Value for address load |
| busy | output | 1 | Operation in progress |
| ead | output | 18 | Current execute address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 18 | Memory word address |
| mem_wdata | output | 16 | Memory write word |
| mem_be | output | 2 | Byte-lane write enables |
| mem_rdata | input | 16 | Memory read word |
| mem_rvalid | input | 1 | Read word valid |

## Verification
The hardest situations to reach are these:
- a merging write whose read returns late, in the middle of a repeated run;
- an address load that arrives while such a run is in progress.

The bench memory model therefore adds a programmable extra read latency that changes between operations. The driver raises `addr_load` on the first busy cycle of a repeated run, then checks that the final `ead` still follows the stepped sequence. Address wrap is reached by loading addresses next to both ends of the 18-bit space. One case uses a positive step and the other a negative vertical step.

// File: rtl/dw_pkg.sv
package dw_pkg;
    typedef enum logic [1:0] {
        OP_REPLACE = 2'd0,
        OP_XOR     = 2'd1,
        OP_CLEAR   = 2'd2,
        OP_SET     = 2'd3
    } dw_op_e;

    typedef enum logic [1:0] {
        LN_WORD = 2'd0,
        LN_BAD  = 2'd1,
        LN_LOW  = 2'd2,
        LN_HIGH = 2'd3
    } dw_lane_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WAIT,
        ST_WRITE
    } dw_state_e;
endpackage

// File: rtl/dw_lane_alu.sv
module dw_lane_alu
    import dw_pkg::*;
#(
    parameter int DATA_W = 16,
    localparam int LANES = DATA_W / 8
) (
    input  logic [1:0]        op,
    input  logic [1:0]        lane_sel,
    input  logic [DATA_W-1:0] old_word,
    input  logic [DATA_W-1:0] data,
    output logic [DATA_W-1:0] new_word,
    output logic [LANES-1:0]  lane_en
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] o_b, d_b;
        assign o_b = old_word[g*8 +: 8];
        assign d_b = data[g*8 +: 8];

        always_comb begin
            unique case (dw_op_e'(op))
                OP_REPLACE: new_word[g*8 +: 8] = d_b;
                OP_XOR:     new_word[g*8 +: 8] = o_b ^ d_b;
                OP_CLEAR:   new_word[g*8 +: 8] = o_b & ~d_b;
                OP_SET:     new_word[g*8 +: 8] = o_b | d_b;
                default:    new_word[g*8 +: 8] = d_b;
            endcase
        end

        always_comb begin
            unique case (dw_lane_e'(lane_sel))
                LN_WORD: lane_en[g] = 1'b1;
                LN_LOW:  lane_en[g] = (g == 0);
                LN_HIGH: lane_en[g] = (g == LANES - 1);
                default: lane_en[g] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/dw_addr_step.sv
module dw_addr_step #(
    parameter int ADDR_W  = 18,
    parameter int PITCH_W = 8,
    localparam int EXT_W  = ADDR_W + PITCH_W + 3
) (
    input  logic [ADDR_W-1:0]  cur,
    input  logic [1:0]         sx,
    input  logic [1:0]         sy,
    input  logic [PITCH_W-1:0] pitch,
    output logic [ADDR_W-1:0]  nxt
);
    logic signed [EXT_W-1:0] cur_e, sx_e, sy_e, p_e, prod, sum;

    always_comb begin
        cur_e = {{(EXT_W-ADDR_W){1'b0}}, cur};
        sx_e  = {{(EXT_W-2){sx[1]}}, sx};
        sy_e  = {{(EXT_W-2){sy[1]}}, sy};
        p_e   = {{(EXT_W-PITCH_W){1'b0}}, pitch};
        prod  = sy_e * p_e;
        sum   = cur_e + sx_e + prod;
        nxt   = sum[ADDR_W-1:0];
    end
endmodule

// File: rtl/dw_seq.sv
module dw_seq
    import dw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic start_rmw,
    input  logic loop_rmw,
    input  logic last,
    input  logic rvalid,
    output logic rd,
    output logic wr,
    output logic busy,
    output logic capture,
    output dw_state_e state
);
    dw_state_e nstate;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:  if (start) nstate = start_rmw ? ST_READ : ST_WRITE;
            ST_READ:  nstate = ST_WAIT;
            ST_WAIT:  if (rvalid) nstate = ST_WRITE;
            ST_WRITE: begin
                if (last)          nstate = ST_IDLE;
                else if (loop_rmw) nstate = ST_READ;
                else               nstate = ST_WRITE;
            end
            default:  nstate = ST_IDLE;
        endcase
    end

    always_comb begin
        rd      = (state == ST_READ);
        wr      = (state == ST_WRITE);
        busy    = (state != ST_IDLE);
        capture = (state == ST_WAIT) && rvalid;
    end
endmodule

// File: rtl/dw_rmw_unit.sv
module dw_rmw_unit
    import dw_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = 18,
    parameter int PITCH_W = 8,
    parameter int CNT_W   = 8,
    localparam int LANES  = DATA_W / 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [1:0]         req_mode,
    input  logic [1:0]         req_type,
    input  logic [DATA_W-1:0]  req_data,
    input  logic [CNT_W-1:0]   req_count,
    input  logic [1:0]         step_x,
    input  logic [1:0]         step_y,
    input  logic [PITCH_W-1:0] pitch,
    input  logic               addr_load,
    input  logic [ADDR_W-1:0]  addr_value,
    output logic               busy,
    output logic [ADDR_W-1:0]  ead,
    output logic               mem_rd,
    output logic               mem_wr,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    output logic [LANES-1:0]   mem_be,
    input  logic [DATA_W-1:0]  mem_rdata,
    input  logic               mem_rvalid
);
    logic [DATA_W-1:0]  data_q, old_q;
    logic [1:0]         mode_q, type_q, sx_q, sy_q;
    logic [PITCH_W-1:0] pitch_q;
    logic [CNT_W-1:0]   remain_q;
    logic [ADDR_W-1:0]  ead_nxt;
    logic               accept, capture, last;
    dw_state_e          state;

    assign accept = req_valid && !busy && (dw_lane_e'(req_type) != LN_BAD);
    assign last   = (remain_q == '0);

    dw_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .start_rmw (dw_op_e'(req_mode) != OP_REPLACE),
        .loop_rmw  (dw_op_e'(mode_q) != OP_REPLACE),
        .last      (last),
        .rvalid    (mem_rvalid),
        .rd        (mem_rd),
        .wr        (mem_wr),
        .busy      (busy),
        .capture   (capture),
        .state     (state)
    );

    dw_lane_alu #(.DATA_W(DATA_W)) u_alu (
        .op       (mode_q),
        .lane_sel (type_q),
        .old_word (old_q),
        .data     (data_q),
        .new_word (mem_wdata),
        .lane_en  (mem_be)
    );

    dw_addr_step #(.ADDR_W(ADDR_W), .PITCH_W(PITCH_W)) u_step (
        .cur   (ead),
        .sx    (sx_q),
        .sy    (sy_q),
        .pitch (pitch_q),
        .nxt   (ead_nxt)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q   <= '0;
            mode_q   <= '0;
            type_q   <= '0;
            sx_q     <= '0;
            sy_q     <= '0;
            pitch_q  <= '0;
            remain_q <= '0;
        end else if (accept) begin
            data_q   <= req_data;
            mode_q   <= req_mode;
            type_q   <= req_type;
            sx_q     <= step_x;
            sy_q     <= step_y;
            pitch_q  <= pitch;
            remain_q <= req_count;
        end else if (mem_wr && !last) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       old_q <= '0;
        else if (capture) old_q <= mem_rdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                 ead <= '0;
        else if (!busy && addr_load) ead <= addr_value;
        else if (mem_wr)            ead <= ead_nxt;
    end

    assign mem_addr = ead;
endmodule

// File: rtl/dw_rmw_checker.sv
module dw_rmw_checker #(
    parameter int ADDR_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        req_type,
    input logic [1:0]        mode_q,
    input logic              addr_load,
    input logic              busy,
    input logic [ADDR_W-1:0] ead,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [1:0]        mem_be
);
    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr)); // R9
    AST_REPLACE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mode_q == 2'd0) |-> !mem_rd); // R9
    AST_WR_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr || mem_rd) |-> busy); // R10
    AST_BAD_LANE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && req_type == 2'd1) |=> !busy); // R6
    AST_LANE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (mem_be != 2'b00)); // R5
    AST_LOAD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && addr_load && !mem_wr) |=> $stable(ead)); // R11
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !addr_load) |=> $stable(ead)); // R7
endmodule

bind dw_rmw_unit dw_rmw_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_type  (req_type),
    .mode_q    (mode_q),
    .addr_load (addr_load),
    .busy      (busy),
    .ead       (ead),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_be    (mem_be)
);

// File: tb/sim_dw_rmw_unit.sv
`timescale 1ns/1ps
module sim_dw_rmw_unit;
    localparam int AW = 18;

    logic        clk = 0, rst_n = 0;
    logic        req_valid = 0, addr_load = 0;
    logic [1:0]  req_mode = 0, req_type = 0, step_x = 0, step_y = 0;
    logic [15:0] req_data = 0;
    logic [7:0]  req_count = 0, pitch = 0;
    logic [AW-1:0] addr_value = 0;
    logic        busy, mem_rd, mem_wr, mem_rvalid = 0;
    logic [AW-1:0] ead, mem_addr;
    logic [15:0] mem_wdata, mem_rdata = 0;
    logic [1:0]  mem_be;

    always #5 clk = ~clk;

    dw_rmw_unit u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .req_type(req_type), .req_data(req_data), .req_count(req_count),
        .step_x(step_x), .step_y(step_y), .pitch(pitch), .addr_load(addr_load),
        .addr_value(addr_value), .busy(busy), .ead(ead), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_be(mem_be), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid)
    );

    typedef struct {
        logic [AW-1:0] addr;
        logic [1:0]    be;
        logic [15:0]   word;
        string         tag;
    } exp_t;

    exp_t        sb[$];
    logic [15:0] vram   [1024];
    logic [15:0] shadow [1024];
    int          checks = 0, fails = 0, wr_seen = 0, rd_seen = 0;
    int          lat_extra = 0, rd_cnt = 0;
    logic [AW-1:0] rd_addr = 0, ead_model = 0;
    bit          done = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // memory model: writes at the clock edge, reads answer after 1+lat_extra cycles
    always @(posedge clk)
        if (mem_wr) begin
            if (mem_be[0]) vram[mem_addr[9:0]][7:0]  <= mem_wdata[7:0];
            if (mem_be[1]) vram[mem_addr[9:0]][15:8] <= mem_wdata[15:8];
        end

    always @(negedge clk) begin
        mem_rvalid <= 1'b0;
        if (mem_rd) begin
            rd_cnt  <= lat_extra + 1;
            rd_addr <= mem_addr;
        end else if (rd_cnt == 1) begin
            mem_rvalid <= 1'b1;
            mem_rdata  <= vram[rd_addr[9:0]];
            rd_cnt     <= 0;
        end else if (rd_cnt > 1) begin
            rd_cnt <= rd_cnt - 1;
        end
    end

    // monitor: pops the scoreboard on each write
    always @(negedge clk) begin
        if (mem_rd) rd_seen++;
        if (mem_wr) begin
            wr_seen++;
            if (sb.size() == 0) begin
                chk(0, "R8 unexpected write", longint'(mem_addr), 0);
            end else begin
                exp_t e;
                logic [15:0] m;
                e = sb.pop_front();
                m = {{8{e.be[1]}}, {8{e.be[0]}}};
                chk(mem_addr == e.addr, {e.tag, " R7 addr"}, longint'(mem_addr), longint'(e.addr));
                chk(mem_be == e.be, {e.tag, " R5 lanes"}, longint'(mem_be), longint'(e.be));
                chk((mem_wdata & m) == e.word, {e.tag, " data"},
                    longint'(mem_wdata & m), longint'(e.word));
            end
        end
    end

    function automatic logic [AW-1:0] step_addr(logic [AW-1:0] a, logic [1:0] sx,
                                                 logic [1:0] sy, logic [7:0] p);
        int v;
        v = int'(a) + int'($signed(sx)) + int'($signed(sy)) * int'(p);
        return AW'(v);
    endfunction

    task automatic load_addr(input logic [AW-1:0] a);
        @(negedge clk);
        addr_load = 1; addr_value = a;
        @(negedge clk);
        addr_load = 0;
        ead_model = a;
        chk(ead == a, "R11 idle load", longint'(ead), longint'(a));
    endtask

    task automatic run_op(input logic [1:0] mode, input logic [1:0] typ,
                          input logic [15:0] data, input int cnt,
                          input logic [1:0] sx, input logic [1:0] sy,
                          input logic [7:0] p, input int extra,
                          input bit poke, input string tag);
        logic [AW-1:0] e;
        logic [1:0]    be;
        int            bcyc, exp_cyc, exp_rd;
        e = ead_model;
        be = (typ == 2'd0) ? 2'b11 : (typ == 2'd2) ? 2'b01 : (typ == 2'd3) ? 2'b10 : 2'b00;
        if (typ != 2'd1) begin
            for (int i = 0; i <= cnt; i++) begin
                logic [15:0] o, n, m;
                exp_t it;
                o = shadow[e[9:0]];
                case (mode)
                    2'd0: n = data;
                    2'd1: n = o ^ data;
                    2'd2: n = o & ~data;
                    default: n = o | data;
                endcase
                m = {{8{be[1]}}, {8{be[0]}}};
                it.addr = e; it.be = be; it.word = n & m; it.tag = tag;
                sb.push_back(it);
                shadow[e[9:0]] = (n & m) | (o & ~m);
                e = step_addr(e, sx, sy, p);
            end
        end
        exp_cyc = (typ == 2'd1) ? 0 : (cnt + 1) * ((mode == 2'd0) ? 1 : 3 + extra);
        exp_rd  = (typ == 2'd1 || mode == 2'd0) ? 0 : cnt + 1;
        @(negedge clk);
        lat_extra = extra; wr_seen = 0; rd_seen = 0;
        req_valid = 1; req_mode = mode; req_type = typ; req_data = data;
        req_count = 8'(cnt); step_x = sx; step_y = sy; pitch = p;
        @(negedge clk);
        req_valid = 0;
        chk(busy == (typ != 2'd1), {tag, " R10 busy rise"}, longint'(busy), longint'(typ != 2'd1));
        bcyc = 0;
        while (busy) begin
            bcyc++;
            addr_load = poke && (bcyc == 1);
            addr_value = 18'h2AAAA;
            @(negedge clk);
        end
        addr_load = 0;
        chk(bcyc == exp_cyc, {tag, " R10 busy length"}, longint'(bcyc), longint'(exp_cyc));
        chk(rd_seen == exp_rd, {tag, " R9 reads"}, longint'(rd_seen), longint'(exp_rd));
        chk(wr_seen == ((typ == 2'd1) ? 0 : cnt + 1), {tag, " R8 writes"},
            longint'(wr_seen), longint'((typ == 2'd1) ? 0 : cnt + 1));
        chk(ead == e, {tag, " R7 final ead"}, longint'(ead), longint'(e));
        chk(sb.size() == 0, {tag, " pending"}, longint'(sb.size()), 0);
        sb.delete();
        ead_model = e;
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) begin
            vram[i]   = 16'(i * 40503) ^ 16'h5A5A;
            shadow[i] = 16'(i * 40503) ^ 16'h5A5A;
        end
        repeat (3) @(negedge clk);
        chk(busy == 0 && mem_rd == 0 && mem_wr == 0 && ead == 0, "R12 reset",
            longint'({busy, mem_rd, mem_wr}), 0);
        rst_n = 1;
        @(negedge clk);
        chk(ead == 0 && !busy, "R12 after release", longint'(ead), 0);

        load_addr(18'h100);
        run_op(2'd0, 2'd0, 16'hA5C3, 0, 2'b01, 2'b00, 8'd0, 0, 0, "R1 replace word");
        run_op(2'd0, 2'd2, 16'h1234, 1, 2'b01, 2'b00, 8'd0, 0, 0, "R1 R5 replace low");
        load_addr(18'h120);
        run_op(2'd1, 2'd2, 16'hFF0F, 2, 2'b01, 2'b00, 8'd0, 0, 0, "R2 R5 xor low");
        run_op(2'd1, 2'd0, 16'h0FF0, 1, 2'b00, 2'b01, 8'd40, 2, 0, "R2 xor word late read");
        run_op(2'd2, 2'd3, 16'hF0AA, 2, 2'b00, 2'b01, 8'd40, 1, 0, "R3 R5 clear high");
        run_op(2'd3, 2'd0, 16'h8001, 3, 2'b11, 2'b00, 8'd0, 0, 0, "R4 R8 set word");
        run_op(2'd3, 2'd1, 16'hFFFF, 2, 2'b01, 2'b00, 8'd0, 0, 0, "R6 bad lane");
        load_addr(18'h3FFFF);
        run_op(2'd0, 2'd0, 16'hBEEF, 1, 2'b01, 2'b00, 8'd0, 0, 0, "R7 wrap up");
        load_addr(18'd10);
        run_op(2'd1, 2'd3, 16'h5500, 0, 2'b00, 2'b11, 8'd80, 1, 0, "R7 wrap down");
        load_addr(18'h200);
        run_op(2'd2, 2'd0, 16'h00FF, 2, 2'b01, 2'b01, 8'd16, 1, 1, "R11 load while busy");
        run_op(2'd0, 2'd3, 16'h7700, 3, 2'b10, 2'b00, 8'd0, 0, 1, "R11 replace poke");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule